// File: doc/BRIEF.md
# Serializer Loopback Router

This block sits between the transmit and receive serializers of a multichannel TDM serial audio port and the device pads. In normal operation each receive serializer hears its own pad. For self-test it can instead feed each receiving serializer from a paired transmitting serializer. Software can then compare the received words with the words it sent.

Loopback can take two paths. The internal path takes the partner's transmit data straight inside the module. The pad path reads the partner's pad input back, so the pad buffers are part of the test. While loopback runs, the receive section can be moved onto the transmit bit clock and frame sync, so that both sections run in step.

A five-bit control word holds enable, pairing order, a two-bit clock mode and the path select. Enable and pairing changes are held back until the next transmit frame start, so no frame is ever split across two routings. Loopback is only honoured while the transmit framing field names a TDM frame of 2 to 32 slots. A status output tells whether loopback is really in force.

Top module: `lb_router`

## Requirements
- R1: After reset the control readback is 0, `lb_active` is 0, every `ser_rx_data` bit equals its own `pad_in` bit, and the receive clock outputs follow `rx_bclk`/`rx_fs`.
- R2: A cycle with `cfg_wr` high stores `cfg_wdata` into the control word, and `cfg_rdata` returns it from the next cycle on. The fields are bit 0 enable, bit 1 pairing order, bits 3:2 clock mode and bit 4 path select (0 internal, 1 pad).
- R3: `lb_active` is 1 only when the applied enable is 1 and `tx_mode` lies in 2..32. The values 0 (burst) and 0x180 (digital audio interface), like any other value outside that range, force it to 0.
- R4: Enable and order written to the control word are applied only at a transmit frame start. A frame start is a clock cycle with `tx_fs` high that follows one with `tx_fs` low. The new routing shows from the cycle after that frame start.
- R5: While loopback is active with order 0 on the internal path, each odd lane i receives `ser_tx_data[i-1]` and each even lane receives its own pad.
- R6: While loopback is active with order 1 on the internal path, each even lane i that has a lane i+1 receives `ser_tx_data[i+1]`, and every other lane receives its own pad.
- R7: On the internal path the loopback routing does not depend on `pin_func` or `pin_dir`.
- R8: `pad_oe[i]` is 1 exactly when `pin_func[i]` is 0 (port function) and `pin_dir[i]` is 1 (output). `pad_out` always carries `ser_tx_data`, on either path and whether loopback is on or off.
- R9: While loopback is active on the pad path, each receiving lane takes `pad_in` of its partner lane, following the R5/R6 pairing. The other lanes keep their own pad.
- R10: While loopback is inactive, every lane receives its own `pad_in` bit, whatever the order and path bits hold.
- R11: `rx_bclk_sel`/`rx_fs_sel` follow `tx_bclk`/`tx_fs` when loopback is active, the clock mode is 1 and `clk_async` is 0. Otherwise they follow `rx_bclk`/`rx_fs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 5 | Control word write data |
| cfg_rdata | output | 5 | Control word readback |
| tx_mode | input | 9 | Transmit framing field (slot count) |
| clk_async | input | 1 | Transmit/receive clocks independent when 1 |
| ser_tx_data | input | N | Transmit serializer data, one bit per lane |
| pin_func | input | N | Per-pin function (0 port, 1 GPIO) |
| pin_dir | input | N | Per-pin direction (1 output) |
| pad_in | input | N | Pad input buffers |
| pad_out | output | N | Pad output data |
| pad_oe | output | N | Pad output enables |
| ser_rx_data | output | N | Receive serializer input data |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_bclk_sel | output | 1 | Bit clock handed to the receive section |
| rx_fs_sel | output | 1 | Frame sync handed to the receive section |
| lb_active | output | 1 | Loopback in force |

## Verification
The bench builds the router with six lanes. With six lanes, both pairing patterns take effect on every pair. The order-1 rule for an even lane without a partner lies outside this build; that case needs an odd lane count. The bench models each pad: it returns `pad_out` when the pin is driven and an independent external value when it is not. This lets the pad-path cases show a partner whose pin is turned off.

// File: rtl/lb_router_pkg.sv
package lb_router_pkg;
  localparam int CFG_W    = 5;
  localparam int TXMODE_W = 9;
  localparam int TDM_MIN  = 2;
  localparam int TDM_MAX  = 32;

  typedef struct packed {
    logic       path_pad;   // bit 4
    logic [1:0] clk_mode;   // bits 3:2
    logic       order;      // bit 1
    logic       enable;     // bit 0
  } lb_cfg_t;

  localparam logic [1:0] CLKMODE_SYNC = 2'd1;

  function automatic logic mode_is_tdm(input logic [TXMODE_W-1:0] m);
    return (m >= TXMODE_W'(TDM_MIN)) && (m <= TXMODE_W'(TDM_MAX));
  endfunction
endpackage

// File: rtl/lb_cfg_regs.sv
module lb_cfg_regs
  import lb_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             frame_sync,
  output lb_cfg_t          cfg,
  output logic             run_enable,
  output logic             run_order
);
  logic fs_prev;
  logic frame_start;

  assign frame_start = frame_sync & ~fs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      fs_prev <= 1'b0;
    end else begin
      fs_prev <= frame_sync;
      if (wr_en) cfg <= lb_cfg_t'(wr_data);
    end
  end

  // Enable and pairing move to the live copy only at a frame start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_enable <= 1'b0;
      run_order  <= 1'b0;
    end else if (frame_start) begin
      run_enable <= cfg.enable;
      run_order  <= cfg.order;
    end
  end
endmodule

// File: rtl/lb_lane_router.sv
module lb_lane_router #(
  parameter int N = 8
) (
  input  logic         active,
  input  logic         use_pad,
  input  logic         order,
  input  logic [N-1:0] tx_data,
  input  logic [N-1:0] pin_func,
  input  logic [N-1:0] pin_dir,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] rx_data
);
  assign pad_out = tx_data;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign pad_oe[i] = ~pin_func[i] & pin_dir[i];

    if ((i % 2) == 1) begin : g_odd
      // receiver in order 0, partner below
      logic loop_src;
      assign loop_src   = use_pad ? pad_in[i-1] : tx_data[i-1];
      assign rx_data[i] = (active && !order) ? loop_src : pad_in[i];
    end else if (i + 1 < N) begin : g_even
      // receiver in order 1, partner above
      logic loop_src;
      assign loop_src   = use_pad ? pad_in[i+1] : tx_data[i+1];
      assign rx_data[i] = (active && order) ? loop_src : pad_in[i];
    end else begin : g_last
      assign rx_data[i] = pad_in[i];
    end
  end
endmodule

// File: rtl/lb_clk_sel.sv
module lb_clk_sel
  import lb_router_pkg::*;
(
  input  logic       active,
  input  logic [1:0] clk_mode,
  input  logic       clk_async,
  input  logic       tx_bclk,
  input  logic       tx_fs,
  input  logic       rx_bclk,
  input  logic       rx_fs,
  output logic       rx_bclk_sel,
  output logic       rx_fs_sel
);
  logic share_tx;
  assign share_tx    = active && (clk_mode == CLKMODE_SYNC) && !clk_async;
  assign rx_bclk_sel = share_tx ? tx_bclk : rx_bclk;
  assign rx_fs_sel   = share_tx ? tx_fs   : rx_fs;
endmodule

// File: rtl/lb_router.sv
module lb_router
  import lb_router_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic [TXMODE_W-1:0] tx_mode,
  input  logic                clk_async,
  input  logic [N-1:0]        ser_tx_data,
  input  logic [N-1:0]        pin_func,
  input  logic [N-1:0]        pin_dir,
  input  logic [N-1:0]        pad_in,
  output logic [N-1:0]        pad_out,
  output logic [N-1:0]        pad_oe,
  output logic [N-1:0]        ser_rx_data,
  input  logic                tx_bclk,
  input  logic                tx_fs,
  input  logic                rx_bclk,
  input  logic                rx_fs,
  output logic                rx_bclk_sel,
  output logic                rx_fs_sel,
  output logic                lb_active
);
  lb_cfg_t cfg;
  logic    run_enable;
  logic    run_order;

  lb_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .wr_data    (cfg_wdata),
    .frame_sync (tx_fs),
    .cfg        (cfg),
    .run_enable (run_enable),
    .run_order  (run_order)
  );

  assign cfg_rdata = cfg;
  assign lb_active = run_enable && mode_is_tdm(tx_mode);

  lb_lane_router #(.N(N)) u_lanes (
    .active   (lb_active),
    .use_pad  (cfg.path_pad),
    .order    (run_order),
    .tx_data  (ser_tx_data),
    .pin_func (pin_func),
    .pin_dir  (pin_dir),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .rx_data  (ser_rx_data)
  );

  lb_clk_sel u_clk (
    .active      (lb_active),
    .clk_mode    (cfg.clk_mode),
    .clk_async   (clk_async),
    .tx_bclk     (tx_bclk),
    .tx_fs       (tx_fs),
    .rx_bclk     (rx_bclk),
    .rx_fs       (rx_fs),
    .rx_bclk_sel (rx_bclk_sel),
    .rx_fs_sel   (rx_fs_sel)
  );
endmodule

// File: rtl/lb_router_chk.sv
module lb_router_chk
  import lb_router_pkg::*;
#(
  parameter int N = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CFG_W-1:0]    cfg_rdata,
  input logic [TXMODE_W-1:0] tx_mode,
  input logic                clk_async,
  input logic [N-1:0]        pin_func,
  input logic [N-1:0]        pin_dir,
  input logic [N-1:0]        pad_in,
  input logic [N-1:0]        pad_oe,
  input logic [N-1:0]        ser_rx_data,
  input logic                tx_fs,
  input logic                rx_fs,
  input logic                rx_fs_sel,
  input logic                lb_active
);
  logic fs_seen;
  logic start_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_seen <= 1'b0;
      start_d <= 1'b0;
    end else begin
      fs_seen <= tx_fs;
      start_d <= tx_fs & ~fs_seen;
    end
  end

  AST_IDLE_OWN_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_active |-> (ser_rx_data == pad_in)); // R10

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_mode < 9'd2) || (tx_mode > 9'd32)) |-> !lb_active); // R3

  AST_APPLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ((lb_active != $past(lb_active)) && $stable(tx_mode)) |-> start_d); // R4

  AST_SYNC_FS: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_active && (cfg_rdata[3:2] == 2'd1) && !clk_async && $stable(cfg_rdata))
      |-> (rx_fs_sel == tx_fs)); // R11

  AST_IDLE_FS: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_active |-> (rx_fs_sel == rx_fs)); // R11

  AST_NO_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pin_func) == '0) && ((pad_oe & ~pin_dir) == '0)); // R8
endmodule

bind lb_router lb_router_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rdata   (cfg_rdata),
  .tx_mode     (tx_mode),
  .clk_async   (clk_async),
  .pin_func    (pin_func),
  .pin_dir     (pin_dir),
  .pad_in      (pad_in),
  .pad_oe      (pad_oe),
  .ser_rx_data (ser_rx_data),
  .tx_fs       (tx_fs),
  .rx_fs       (rx_fs),
  .rx_fs_sel   (rx_fs_sel),
  .lb_active   (lb_active)
);

// File: tb/lb_router_test.sv
`timescale 1ns/1ps
module lb_router_test;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [4:0]   cfg_wdata = '0;
  logic [4:0]   cfg_rdata;
  logic [8:0]   tx_mode = 9'd8;
  logic         clk_async = 1'b0;
  logic [N-1:0] ser_tx_data = '0;
  logic [N-1:0] pin_func = '0;
  logic [N-1:0] pin_dir = '0;
  logic [N-1:0] ext_in = '0;
  logic [N-1:0] pad_in;
  logic [N-1:0] pad_out, pad_oe, ser_rx_data;
  logic         tx_bclk = 1'b0, tx_fs = 1'b0, rx_bclk = 1'b0, rx_fs = 1'b0;
  logic         rx_bclk_sel, rx_fs_sel, lb_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // pad model: a driven pin reads back its own output
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  lb_router #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_mode(tx_mode), .clk_async(clk_async),
    .ser_tx_data(ser_tx_data), .pin_func(pin_func), .pin_dir(pin_dir),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ser_rx_data(ser_rx_data), .tx_bclk(tx_bclk), .tx_fs(tx_fs),
    .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_bclk_sel(rx_bclk_sel),
    .rx_fs_sel(rx_fs_sel), .lb_active(lb_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] want_rx(input bit act, input bit ord, input bit viapad,
                                           input logic [N-1:0] tx, input logic [N-1:0] pin);
    logic [N-1:0] r;
    r = pin;
    if (act) begin
      for (int i = 0; i < N; i++) begin
        if (!ord && (i % 2 == 1)) r[i] = viapad ? pin[i-1] : tx[i-1];
        if (ord && (i % 2 == 0) && (i + 1 < N)) r[i] = viapad ? pin[i+1] : tx[i+1];
      end
    end
    return r;
  endfunction

  task automatic wr(input logic [4:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); tx_fs = 1'b1;
    @(negedge clk); tx_fs = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    ext_in = 6'b101101;
    #1;
    check("R1 readback", cfg_rdata, 0);
    check("R1 active", lb_active, 0);
    check("R1 rx", ser_rx_data, ext_in);
    rx_fs = 1'b1; #1;
    check("R1 fs", rx_fs_sel, 1);
    rx_fs = 1'b0;
  endtask

  task automatic t_regs();
    wr(5'b10110); #1;
    check("R2 readback a", cfg_rdata, 5'b10110);
    wr(5'b01001); #1;
    check("R2 readback b", cfg_rdata, 5'b01001);
    wr(5'b00000);
    frame();
  endtask

  task automatic t_boundary();
    tx_mode = 9'd8;
    wr(5'b00001); #1;
    check("R4 before frame", lb_active, 0);
    @(negedge clk); tx_fs = 1'b1; #1;
    check("R4 at fs edge", lb_active, 0);
    @(negedge clk); #1;
    check("R4 after frame", lb_active, 1);
    tx_fs = 1'b0;
    wr(5'b00011);  // order change waits for frame
    ser_tx_data = 6'b010101; ext_in = 6'b000000; #1;
    check("R4 order held", ser_rx_data, want_rx(1, 0, 0, ser_tx_data, pad_in));
    frame(); #1;
    check("R4 order applied", ser_rx_data, want_rx(1, 1, 0, ser_tx_data, pad_in));
  endtask

  task automatic t_mode_gate();
    logic [8:0] modes[6] = '{9'd0, 9'h180, 9'd1, 9'd33, 9'd2, 9'd32};
    bit         exp[6]   = '{0, 0, 0, 0, 1, 1};
    wr(5'b00001); frame();
    for (int k = 0; k < 6; k++) begin
      tx_mode = modes[k]; #1;
      check($sformatf("R3 mode %0h", modes[k]), lb_active, exp[k]);
    end
    tx_mode = 9'd8;
  endtask

  task automatic t_order0();
    wr(5'b00001); frame();
    pin_func = '0; pin_dir = '0;
    ser_tx_data = 6'b110010; ext_in = 6'b011011; #1;
    check("R5 order0 a", ser_rx_data, want_rx(1, 0, 0, ser_tx_data, pad_in));
    ser_tx_data = 6'b001101; #1;
    check("R5 order0 b", ser_rx_data, want_rx(1, 0, 0, ser_tx_data, pad_in));
  endtask

  task automatic t_order1();
    wr(5'b00011); frame();
    ser_tx_data = 6'b101010; ext_in = 6'b010101; #1;
    check("R6 order1 a", ser_rx_data, want_rx(1, 1, 0, ser_tx_data, pad_in));
    ser_tx_data = 6'b011100; #1;
    check("R6 order1 b", ser_rx_data, want_rx(1, 1, 0, ser_tx_data, pad_in));
  endtask

  task automatic t_pin_ignore();
    wr(5'b00001); frame();
    ser_tx_data = 6'b100110; ext_in = 6'b000000;
    pin_func = '1; pin_dir = '0; #1;
    check("R7 gpio pins", ser_rx_data, want_rx(1, 0, 0, ser_tx_data, 6'b000000));
    pin_func = '0; pin_dir = '1; ext_in = 6'b111111; #1;
    check("R7 output pins", ser_rx_data, want_rx(1, 0, 0, ser_tx_data, pad_in));
  endtask

  task automatic t_pad_drive();
    ser_tx_data = 6'b101100;
    pin_func = 6'b000011; pin_dir = 6'b010101; #1;
    check("R8 oe", pad_oe, 6'b010100);
    check("R8 out", pad_out, 6'b101100);
  endtask

  task automatic t_pad_path();
    wr(5'b10001); frame();
    pin_func = '0; pin_dir = '1; ext_in = 6'b000000;
    ser_tx_data = 6'b010110; #1;
    check("R9 pad loop", ser_rx_data, want_rx(1, 0, 1, ser_tx_data, pad_in));
    pin_dir = 6'b111110; ext_in = 6'b000001; ser_tx_data = 6'b000000; #1;
    check("R9 undriven partner", ser_rx_data[1], 1'b1);
    wr(5'b10011); frame();
    pin_dir = '1; ser_tx_data = 6'b100100; #1;
    check("R9 pad order1", ser_rx_data, want_rx(1, 1, 1, ser_tx_data, pad_in));
  endtask

  task automatic t_idle();
    wr(5'b10010); frame();
    pin_dir = '0; ext_in = 6'b110001; ser_tx_data = 6'b001110; #1;
    check("R10 disabled", ser_rx_data, ext_in);
    wr(5'b00001); frame();
    tx_mode = 9'h180; #1;
    check("R10 suppressed", ser_rx_data, ext_in);
    tx_mode = 9'd8;
  endtask

  task automatic t_clock();
    wr(5'b00101); frame();
    tx_bclk = 1'b1; rx_bclk = 1'b0; clk_async = 1'b0; #1;
    check("R11 shared bclk", rx_bclk_sel, 1);
    clk_async = 1'b1; #1;
    check("R11 async", rx_bclk_sel, 0);
    clk_async = 1'b0;
    wr(5'b01001); #1;
    check("R11 mode2", rx_bclk_sel, 0);
    wr(5'b00100); frame(); #1;
    check("R11 disabled", rx_bclk_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_boundary();
    t_mode_gate();
    t_order0();
    t_order1();
    t_pin_ignore();
    t_pad_drive();
    t_pad_path();
    t_idle();
    t_clock();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule